// File: doc/BRIEF.md
# Serial-Addressed Octal Code Register Bank

This block holds eight 8-bit trim codes, each meant to drive its own converter channel, and loads them from a three-wire serial host port. The port has an active-low select, a shift clock and a data line. A command word of eleven bits carries a 3-bit channel number followed by an 8-bit code. The code is written into the selected channel when the select line returns high, but only if exactly eleven bits were shifted while it was low.

All three serial lines are brought into the system clock domain through two-flop synchronizers. Edges of the shift clock and of the select line are found by comparing each synchronized value with its previous sample.

An asynchronous reset puts every channel at midscale. An active-low shutdown input raises a power-down flag and leaves the stored codes untouched. Writes are still taken during shutdown, so a host can stage new codes before it wakes the channels. Each accepted write is reported by a one-cycle strobe along with the channel number it touched.

Top module: `octalTrimBank`

## Requirements
- R1: A frame is shifted most significant bit first, on rising edges of `sclk` while `csN` is low. Its first 3 bits are the channel number and its last 8 bits are the code. Channel `a` is presented on `codes[8*a+7:8*a]`.
- R2: A committed frame changes only the addressed channel. The other seven channels keep their codes.
- R3: The new code is visible on `codes` no later than the third rising `clk` edge after `csN` rises.
- R4: While `rstN` is low, every channel reads 8'h80, with no clock needed. A frame in progress when reset is applied is abandoned.
- R5: Rising edges of `sclk` while `csN` is high shift nothing into the frame.
- R6: When `csN` rises after any number of `sclk` rising edges other than 11, no channel changes and no strobe is produced.
- R7: `shutdownActive` follows the inverse of `shdnN`, two `clk` cycles later. Entering or leaving shutdown does not alter any code, and frames sent during shutdown are committed.
- R8: Each committed frame raises `updateStrobe` for exactly one `clk` cycle, in the same cycle the new code appears, with `updateAddr` equal to the channel number. At all other times `updateStrobe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset; presets codes to midscale |
| sclk | input | 1 | Serial shift clock |
| csN | input | 1 | Active-low frame select; its rising edge ends the frame |
| sdi | input | 1 | Serial data, most significant bit first |
| shdnN | input | 1 | Active-low shutdown request |
| codes | output | 64 | Eight 8-bit channel codes, channel 0 in the low byte |
| shutdownActive | output | 1 | High while shutdown is in effect |
| updateStrobe | output | 1 | One-cycle pulse for each committed write |
| updateAddr | output | 3 | Channel number of the most recent write |

## Verification
The bench builds the block with its default parameters: a 3-bit channel number, 8-bit codes and an 11-bit frame. With only eight channels, random addressing hits every channel, including both the lowest and highest address bits, many times within a few dozen frames. The short frame width also keeps the runs affordable for frames that are one bit short, one bit long, or truncated by a reset in the middle.

// File: rtl/trimbank_pkg.sv
package trimbank_pkg;
  // Strobes from the serial control to the code datapath
  typedef struct packed {
    logic shiftEn;   // take shiftBit into the frame shifter
    logic shiftBit;  // synchronized serial data
    logic commit;    // a complete frame ended; load the addressed channel
  } bankCtl_t;
endpackage

// File: rtl/syncBit.sv
module syncBit #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= {STAGES{RESET_VAL}};
    else       pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/serialCtrl.sv
module serialCtrl
  import trimbank_pkg::*;
#(
  parameter int FRAME_LEN   = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sclk,
  input  logic     csN,
  input  logic     sdi,
  input  logic     shdnN,
  output bankCtl_t ctl,
  output logic     shutdownActive
);
  localparam int NUM_SYNC = 4;
  localparam int CNT_W    = $clog2(FRAME_LEN + 2);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_LEN);
  // idle levels: shdnN high, sdi low, csN high, sclk low
  localparam logic [NUM_SYNC-1:0] SYNC_RST = 4'b1010;

  logic [NUM_SYNC-1:0] rawIn, syncIn;
  assign rawIn = {shdnN, sdi, csN, sclk};

  for (genvar i = 0; i < NUM_SYNC; i++) begin : g_sync
    syncBit #(.STAGES(SYNC_STAGES), .RESET_VAL(SYNC_RST[i])) i_sync (
      .clk(clk), .rstN(rstN), .din(rawIn[i]), .dout(syncIn[i])
    );
  end

  logic sclkS, csS, sdiS, shdnS;
  assign {shdnS, sdiS, csS, sclkS} = syncIn;

  logic sclkPrev, csPrev;
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      sclkPrev <= sclkS;
      csPrev   <= csS;
    end
  end

  logic sclkRise, csRise;
  assign sclkRise = sclkS & ~sclkPrev;
  assign csRise   = csS & ~csPrev;

  // bit counter saturates one past a full frame so long frames stay invalid
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            bitCnt <= '0;
    else if (csS)                         bitCnt <= '0;
    else if (sclkRise && bitCnt != CNT_SAT) bitCnt <= bitCnt + 1'b1;
  end

  always_comb begin
    ctl.shiftEn  = sclkRise & ~csS;
    ctl.shiftBit = sdiS;
    ctl.commit   = csRise & (bitCnt == CNT_FULL);
  end

  assign shutdownActive = ~shdnS;
endmodule

// File: rtl/codeBank.sv
module codeBank
  import trimbank_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] RESET_CODE = 8'h80
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  bankCtl_t                       ctl,
  output logic [(1<<ADDR_W)*DATA_W-1:0]  codes,
  output logic                           updateStrobe,
  output logic [ADDR_W-1:0]              updateAddr
);
  localparam int NUM_CH    = 1 << ADDR_W;
  localparam int FRAME_LEN = ADDR_W + DATA_W;

  logic [FRAME_LEN-1:0] frameReg;
  logic [ADDR_W-1:0]    frameAddr;
  logic [DATA_W-1:0]    frameData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            frameReg <= '0;
    else if (ctl.shiftEn) frameReg <= {frameReg[FRAME_LEN-2:0], ctl.shiftBit};
  end

  assign frameAddr = frameReg[FRAME_LEN-1 -: ADDR_W];
  assign frameData = frameReg[DATA_W-1:0];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [DATA_W-1:0] codeReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                          codeReg <= RESET_CODE;
      else if (ctl.commit && frameAddr == ADDR_W'(ch))    codeReg <= frameData;
    end
    assign codes[ch*DATA_W +: DATA_W] = codeReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      updateStrobe <= 1'b0;
      updateAddr   <= '0;
    end else begin
      updateStrobe <= ctl.commit;
      if (ctl.commit) updateAddr <= frameAddr;
    end
  end
endmodule

// File: rtl/octalTrimBank.sv
module octalTrimBank
  import trimbank_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          sclk,
  input  logic                          csN,
  input  logic                          sdi,
  input  logic                          shdnN,
  output logic [(1<<ADDR_W)*DATA_W-1:0] codes,
  output logic                          shutdownActive,
  output logic                          updateStrobe,
  output logic [ADDR_W-1:0]             updateAddr
);
  localparam int FRAME_LEN = ADDR_W + DATA_W;
  localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

  bankCtl_t ctl;

  serialCtrl #(.FRAME_LEN(FRAME_LEN)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sdi(sdi),
    .shdnN(shdnN), .ctl(ctl), .shutdownActive(shutdownActive)
  );

  codeBank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESET_CODE(MID_CODE)) i_bank (
    .clk(clk), .rstN(rstN), .ctl(ctl), .codes(codes),
    .updateStrobe(updateStrobe), .updateAddr(updateAddr)
  );
endmodule

// File: rtl/trimBankChecker.sv
module trimBankChecker #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          shdnN,
  input logic [(1<<ADDR_W)*DATA_W-1:0] codes,
  input logic                          shutdownActive,
  input logic                          updateStrobe,
  input logic [ADDR_W-1:0]             updateAddr
);
  localparam int NUM_CH = 1 << ADDR_W;
  localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);
  localparam logic [NUM_CH*DATA_W-1:0] MID_ALL = {NUM_CH{MID_CODE}};

  logic [NUM_CH*DATA_W-1:0] prevCodes;
  logic [NUM_CH-1:0]        changedMask;
  logic [NUM_CH-1:0]        addrMask;
  logic [1:0]               sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCodes <= MID_ALL;
      sinceRst  <= '0;
    end else begin
      prevCodes <= codes;
      if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmp
    assign changedMask[ch] = codes[ch*DATA_W +: DATA_W] != prevCodes[ch*DATA_W +: DATA_W];
    assign addrMask[ch]    = updateAddr == ADDR_W'(ch);
  end

  // R2: at most one channel changes per write
  p_one_channel_r2: assert property (@(posedge clk) disable iff (!rstN)
    $countones(changedMask) <= 1);

  // R2, R8: a change happens only with a strobe, on the reported channel
  p_change_needs_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
    (changedMask != '0) |-> (updateStrobe && (changedMask & ~addrMask) == '0));

  // R8: strobe lasts one cycle
  p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    updateStrobe |=> !updateStrobe);

  // R4: leaving reset, every channel is at midscale
  p_reset_mid_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (codes == MID_ALL && !updateStrobe));

  // R7: shutdown flag follows the input two cycles later
  p_shdn_follow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2) |-> (shutdownActive == !$past(shdnN, 2)));
endmodule

bind octalTrimBank trimBankChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_checker (
  .clk(clk), .rstN(rstN), .shdnN(shdnN), .codes(codes),
  .shutdownActive(shutdownActive), .updateStrobe(updateStrobe),
  .updateAddr(updateAddr)
);

// File: tb/test_octalTrimBank.sv
module test_octalTrimBank;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int NUM_CH = 1 << ADDR_W;
  localparam int HALF   = 3;  // sys cycles per serial clock phase

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0, csN = 1'b1, sdi = 1'b0, shdnN = 1'b1;
  logic [NUM_CH*DATA_W-1:0] codes;
  logic shutdownActive, updateStrobe;
  logic [ADDR_W-1:0] updateAddr;

  int checkCount = 0, failCount = 0;
  int strobeCount = 0;
  logic [ADDR_W-1:0] lastStrobeAddr = '0;
  logic [DATA_W-1:0] expCode [NUM_CH];
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  octalTrimBank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_octalTrimBank (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sdi(sdi), .shdnN(shdnN),
    .codes(codes), .shutdownActive(shutdownActive),
    .updateStrobe(updateStrobe), .updateAddr(updateAddr)
  );

  always @(negedge clk) begin
    if (updateStrobe) begin
      strobeCount++;
      lastStrobeAddr = updateAddr;
    end
  end

  function automatic logic [NUM_CH*DATA_W-1:0] packExp();
    logic [NUM_CH*DATA_W-1:0] v;
    for (int c = 0; c < NUM_CH; c++) v[c*DATA_W +: DATA_W] = expCode[c];
    return v;
  endfunction

  function automatic logic [15:0] makeFrame(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    return 16'({a, d});
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic csLow();
    csN = 1'b0; waitCyc(HALF);
  endtask

  task automatic clockBit(logic b);
    sdi = b; waitCyc(HALF);
    sclk = 1'b1; waitCyc(HALF);
    sclk = 1'b0;
  endtask

  task automatic csHigh();
    waitCyc(HALF);
    csN = 1'b1;
    waitCyc(6);
  endtask

  task automatic sendBits(int n, logic [15:0] word);
    csLow();
    for (int i = n - 1; i >= 0; i--) clockBit(word[i]);
    csHigh();
  endtask

  task automatic writeChan(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    sendBits(ADDR_W + DATA_W, makeFrame(a, d));
    expCode[a] = d;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checkCount++; failCount++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finishRun();
    end
  end

  initial begin
    int s0;
    void'($urandom(32'd20240607));
    for (int c = 0; c < NUM_CH; c++) expCode[c] = 8'h80;

    // R4: reset state
    waitCyc(3);
    check("R4 midscale in reset", 64'(codes), 64'(packExp()));
    rstN = 1'b1;
    waitCyc(4);
    check("R4 midscale after reset", 64'(codes), 64'(packExp()));
    check("R7 no shutdown at start", 64'(shutdownActive), 64'd0);
    check("R8 no strobe at start", 64'(strobeCount), 64'd0);

    // R1, R3, R8: directed writes at address extremes
    s0 = strobeCount;
    csLow();
    for (int i = 10; i >= 0; i--) clockBit(makeFrame(3'd0, 8'h3C)[i]);
    waitCyc(HALF);
    csN = 1'b1;
    waitCyc(3);
    expCode[0] = 8'h3C;
    check("R3 code visible three cycles after csN rise", 64'(codes), 64'(packExp()));
    waitCyc(3);
    check("R8 one strobe per write", 64'(strobeCount - s0), 64'd1);
    check("R8 strobe address 0", 64'(lastStrobeAddr), 64'd0);

    writeChan(3'd7, 8'hA5);
    check("R1 channel 7 written msb first", 64'(codes[7*DATA_W +: DATA_W]), 64'hA5);
    check("R2 other channels unchanged", 64'(codes), 64'(packExp()));
    check("R8 strobe address 7", 64'(lastStrobeAddr), 64'd7);

    writeChan(3'd4, 8'h01);
    check("R1 channel 4 data lsb last", 64'(codes), 64'(packExp()));

    // R6: short and long frames are dropped
    s0 = strobeCount;
    sendBits(10, 16'h2FF);
    check("R6 ten-bit frame ignored", 64'(codes), 64'(packExp()));
    sendBits(12, 16'h0F0F);
    check("R6 twelve-bit frame ignored", 64'(codes), 64'(packExp()));
    sendBits(0, 16'h0);
    check("R6 empty frame ignored", 64'(codes), 64'(packExp()));
    check("R6 no strobe on bad frames", 64'(strobeCount - s0), 64'd0);

    // R5: clocks while deselected do not shift
    for (int i = 0; i < 5; i++) clockBit(1'b1);
    writeChan(3'd2, 8'h5A);
    check("R5 idle clocks not shifted", 64'(codes), 64'(packExp()));

    // R4: reset in mid-frame abandons it
    s0 = strobeCount;
    csLow();
    for (int i = 10; i >= 6; i--) clockBit(makeFrame(3'd1, 8'hEE)[i]);
    rstN = 1'b0;
    waitCyc(2);
    for (int c = 0; c < NUM_CH; c++) expCode[c] = 8'h80;
    check("R4 asynchronous preset", 64'(codes), 64'(packExp()));
    rstN = 1'b1;
    for (int i = 5; i >= 0; i--) clockBit(makeFrame(3'd1, 8'hEE)[i]);
    csHigh();
    check("R4 interrupted frame dropped", 64'(codes), 64'(packExp()));
    check("R4 no strobe for interrupted frame", 64'(strobeCount - s0), 64'd0);

    // R7: shutdown keeps codes and accepts writes
    writeChan(3'd3, 8'h77);
    shdnN = 1'b0;
    waitCyc(3);
    check("R7 shutdown flag set", 64'(shutdownActive), 64'd1);
    check("R7 codes kept in shutdown", 64'(codes), 64'(packExp()));
    writeChan(3'd6, 8'hC3);
    check("R7 write accepted in shutdown", 64'(codes), 64'(packExp()));
    shdnN = 1'b1;
    waitCyc(3);
    check("R7 shutdown flag cleared", 64'(shutdownActive), 64'd0);
    check("R7 codes kept after wake", 64'(codes), 64'(packExp()));

    // R1, R2, R6, R8: random mix
    for (int n = 0; n < 40; n++) begin
      int kind;
      logic [ADDR_W-1:0] a;
      logic [DATA_W-1:0] d;
      kind = $urandom_range(0, 5);
      a = ADDR_W'($urandom_range(0, NUM_CH - 1));
      d = DATA_W'($urandom);
      s0 = strobeCount;
      if ($urandom_range(0, 7) == 0) shdnN = ~shdnN;
      if (kind == 0) begin
        sendBits($urandom_range(0, 1) ? 10 : 12, 16'($urandom));
        check("R6 random bad frame dropped", 64'(strobeCount - s0), 64'd0);
      end else begin
        writeChan(a, d);
        check("R8 random strobe address", 64'(lastStrobeAddr), 64'(a));
      end
      check("R2 random bank contents", 64'(codes), 64'(packExp()));
    end

    done = 1;
    finishRun();
  end
endmodule